// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Bank

This peripheral holds three independent 32-bit down counters behind a plain register bus with address, write strobe, write data and combinational read data. Software gives each channel a start value, picks one-shot or periodic operation and enables it. The counter then steps down once per pulse of a shared tick enable. When it expires, a sticky pending flag sets. When the channel's interrupt enable is on, that flag drives the channel's own level interrupt line.

Each channel owns a 0x20-byte window. The window holds:
- a reload register;
- a live count;
- a control word;
- an interrupt word with enable, pending, clear and busy bits;
- a registered copy of the count.

Software reads the registered copy and inverts it to get a rising time base. A periodic channel loaded with all ones and with its interrupt disabled runs as a free 32-bit counter. After an interrupt clear, the channel reports busy for two cycles. Writes to its reload and control registers are dropped during that time.

Top module: `tmr_bank`

## Requirements
- R1: Channel c (0..2) decodes addresses c*0x20 + offset, with offsets 0x00 reload, 0x04 live count, 0x08 control, 0x0C interrupt and 0x10 registered count. Any other offset, and any address of channel index 3 or above, reads 0. After reset every register reads 0.
- R2: Control bit 6 selects periodic (1) or one-shot (0), bit 7 is enable and bit 8 is a free-run qualifier flag. All three read back from the control register. A control write with bit 7 set copies the reload register into the live count.
- R3: While enabled and not at zero, the live count drops by one on each cycle with tick_i high, and it holds when tick_i is low or the channel is disabled.
- R4: A tick while enabled with the live count at zero is an expiry, and it sets the pending flag (interrupt register bit 2). The flag stays set until it is cleared.
- R5: On expiry in one-shot mode, the channel clears its own enable bit and the count stays at zero.
- R6: On expiry in periodic mode, the count reloads from the reload register and counting continues. With a reload of 0xFFFFFFFF this gives an endless free-running counter.
- R7: irq_o[c] is high exactly when channel c's pending flag and its interrupt enable (interrupt register bit 0) are both set.
- R8: Writing 1 to interrupt register bit 3 clears the pending flag, unless an expiry happens in the same cycle, in which case the flag stays set. Bit 3 reads as 0.
- R9: After a clear write, interrupt register bit 4 (busy) reads 1 for exactly the next two cycles.
- R10: While busy, writes to that channel's reload and control registers are ignored, while interrupt register writes still take effect.
- R11: Offset 0x10 returns the live count as it was one cycle earlier, so its bitwise inverse rises as the counter runs.
- R12: Writes, counting, expiry and clear in one channel leave the other channels unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable shared by all channels |
| addr_i | input | 8 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 3 | Per-channel level interrupt |

## Verification
The hardest situations to reach are the collisions: an expiry in the same cycle as a clear, and a reload or control write that lands inside the two-cycle busy window. The stimulus gets there by keeping reload values between 0 and 7 so expiries come often, and by having tick_i high about half the time. It also draws the write address, the offset and the clear bit at random on every cycle, so that random writes hit busy windows and zero crossings many times. Directed phases before the random run cover the free-running all-ones reload and a write placed right after a clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned WIN_W = 5;
  localparam logic [WIN_W-1:0] OFF_LOAD = 5'h00;
  localparam logic [WIN_W-1:0] OFF_CNT  = 5'h04;
  localparam logic [WIN_W-1:0] OFF_CTL  = 5'h08;
  localparam logic [WIN_W-1:0] OFF_INT  = 5'h0C;
  localparam logic [WIN_W-1:0] OFF_RB   = 5'h10;
  localparam int unsigned CTL_PER  = 6;
  localparam int unsigned CTL_EN   = 7;
  localparam int unsigned CTL_FREE = 8;
  localparam int unsigned INT_IE   = 0;
  localparam int unsigned INT_PEND = 2;
  localparam int unsigned INT_CLR  = 3;
  localparam int unsigned INT_BUSY = 4;
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic [N_CH-1:0]   ld_we_o,
  output logic [N_CH-1:0]   ctl_we_o,
  output logic [N_CH-1:0]   int_we_o
);
  localparam int unsigned CH_W = ADDR_W - WIN_W;

  logic [CH_W-1:0]  ch;
  logic [WIN_W-1:0] off;
  assign ch  = addr_i[ADDR_W-1:WIN_W];
  assign off = addr_i[WIN_W-1:0];

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    logic hit;
    assign hit         = we_i && (ch == CH_W'(i));
    assign ld_we_o[i]  = hit && (off == OFF_LOAD);
    assign ctl_we_o[i] = hit && (off == OFF_CTL);
    assign int_we_o[i] = hit && (off == OFF_INT);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ld_we_i,
  input  logic          ctl_we_i,
  input  logic          int_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] int_o,
  output logic [DW-1:0] rb_o,
  output logic          irq_o
);
  logic [DW-1:0] load_q, cnt_q, rb_q;
  logic          per_q, en_q, free_q, ie_q, pend_q;
  logic [1:0]    busy_q;
  logic          busy, ld_we, ctl_we, clr, expire;

  assign busy   = (busy_q != 2'd0);
  // reprogramming is locked out while a clear settles
  assign ld_we  = ld_we_i && !busy;
  assign ctl_we = ctl_we_i && !busy;
  assign clr    = int_we_i && wdata_i[INT_CLR];
  assign expire = en_q && tick_i && (cnt_q == '0) && !ctl_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cnt_q  <= '0;
      rb_q   <= '0;
      per_q  <= 1'b0;
      en_q   <= 1'b0;
      free_q <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 2'd0;
    end else begin
      rb_q <= cnt_q;
      if (ld_we) load_q <= wdata_i;
      if (ctl_we) begin
        per_q  <= wdata_i[CTL_PER];
        en_q   <= wdata_i[CTL_EN];
        free_q <= wdata_i[CTL_FREE];
        if (wdata_i[CTL_EN]) cnt_q <= load_q;
      end else if (en_q && tick_i) begin
        if (cnt_q == '0) begin
          if (per_q) cnt_q <= load_q;
          else       en_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (int_we_i) ie_q <= wdata_i[INT_IE];
      if (expire)   pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      if (clr)       busy_q <= 2'd2;
      else if (busy) busy_q <= busy_q - 2'd1;
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[CTL_PER]  = per_q;
    ctl_o[CTL_EN]   = en_q;
    ctl_o[CTL_FREE] = free_q;
    int_o = '0;
    int_o[INT_IE]   = ie_q;
    int_o[INT_PEND] = pend_q;
    int_o[INT_BUSY] = busy;
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign rb_o   = rb_q;
  assign irq_o  = pend_q && ie_q;

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tick_i && cnt_q != '0 && !ctl_we_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ctl_we_i) |=> $stable(cnt_q)); // R3
  AST_PEND_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(en_q && tick_i && cnt_q == '0)); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !per_q && tick_i && cnt_q == '0 && !ctl_we_i) |=> (!en_q && cnt_q == '0)); // R5
  AST_PERIOD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && per_q && tick_i && cnt_q == '0 && !ctl_we_i) |=> (en_q && cnt_q == $past(load_q))); // R6
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> busy); // R9
  AST_LOCKED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ld_we_i) |=> $stable(load_q)); // R10
  AST_RB_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rb_q == $past(cnt_q))); // R11
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [N_CH-1:0][DW-1:0]  load_i,
  input  logic [N_CH-1:0][DW-1:0]  cnt_i,
  input  logic [N_CH-1:0][DW-1:0]  ctl_i,
  input  logic [N_CH-1:0][DW-1:0]  int_i,
  input  logic [N_CH-1:0][DW-1:0]  rb_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int unsigned CH_W = ADDR_W - WIN_W;

  logic [CH_W-1:0]  ch;
  logic [WIN_W-1:0] off;
  assign ch  = addr_i[ADDR_W-1:WIN_W];
  assign off = addr_i[WIN_W-1:0];

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch == CH_W'(i)) begin
        case (off)
          OFF_LOAD: rdata_o = load_i[i];
          OFF_CNT:  rdata_o = cnt_i[i];
          OFF_CTL:  rdata_o = ctl_i[i];
          OFF_INT:  rdata_o = int_i[i];
          OFF_RB:   rdata_o = rb_i[i];
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0]          ld_we, ctl_we, int_we;
  logic [N_CH-1:0][DW-1:0]  load_v, cnt_v, ctl_v, int_v, rb_v;

  tmr_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_i),
    .we_i    (we_i),
    .ld_we_o (ld_we),
    .ctl_we_o(ctl_we),
    .int_we_o(int_we)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_chan #(.DW(DW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .ld_we_i (ld_we[i]),
      .ctl_we_i(ctl_we[i]),
      .int_we_i(int_we[i]),
      .wdata_i (wdata_i),
      .load_o  (load_v[i]),
      .cnt_o   (cnt_v[i]),
      .ctl_o   (ctl_v[i]),
      .int_o   (int_v[i]),
      .rb_o    (rb_v[i]),
      .irq_o   (irq_o[i])
    );
  end

  tmr_rdmux #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DW(DW)) u_rdmux (
    .addr_i (addr_i),
    .load_i (load_v),
    .cnt_i  (cnt_v),
    .ctl_i  (ctl_v),
    .int_i  (int_v),
    .rb_i   (rb_v),
    .rdata_o(rdata_o)
  );

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ld_we, ctl_we, int_we}) <= 1); // R12
endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  int total = 0;
  int bad = 0;
  string tag = "";

  logic [31:0] m_load[3], m_cnt[3], m_rb[3];
  logic        m_per[3], m_en[3], m_free[3], m_ie[3], m_pend[3];
  int          m_busy[3];

  always #2 clk_i = ~clk_i;

  tmr_bank u_dut (.*);

  function automatic logic [31:0] mread(logic [7:0] a);
    int c = int'(a[7:5]);
    logic [31:0] r = '0;
    if (c < 3) begin
      case (a[4:0])
        5'h00: r = m_load[c];
        5'h04: r = m_cnt[c];
        5'h08: r = {23'd0, m_free[c], m_en[c], m_per[c], 6'd0};
        5'h0C: r = {27'd0, m_busy[c] != 0, 1'b0, m_pend[c], 1'b0, m_ie[c]};
        5'h10: r = m_rb[c];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string off_tag(logic [4:0] o);
    case (o)
      5'h00: return "R1";
      5'h04: return "R3";
      5'h08: return "R2";
      5'h0C: return "R9";
      5'h10: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic mupd(logic [7:0] a, logic w, logic [31:0] d, logic t);
    for (int c = 0; c < 3; c++) begin
      logic sel, blk, wl, wc, wi, clr, ex;
      sel = (int'(a[7:5]) == c);
      blk = (m_busy[c] != 0);
      wl  = w && sel && a[4:0] == 5'h00 && !blk;
      wc  = w && sel && a[4:0] == 5'h08 && !blk;
      wi  = w && sel && a[4:0] == 5'h0C;
      clr = wi && d[3];
      ex  = m_en[c] && t && m_cnt[c] == 0 && !wc;
      m_rb[c] = m_cnt[c];
      if (wc) begin
        m_per[c] = d[6]; m_en[c] = d[7]; m_free[c] = d[8];
        if (d[7]) m_cnt[c] = m_load[c];
      end else if (m_en[c] && t) begin
        if (m_cnt[c] == 0) begin
          if (m_per[c]) m_cnt[c] = m_load[c];
          else m_en[c] = 1'b0;
        end else m_cnt[c] = m_cnt[c] - 1;
      end
      if (wl) m_load[c] = d;
      if (wi) m_ie[c] = d[0];
      if (ex) m_pend[c] = 1'b1;
      else if (clr) m_pend[c] = 1'b0;
      m_busy[c] = clr ? 2 : (m_busy[c] != 0 ? m_busy[c] - 1 : 0);
    end
  endtask

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic step(logic [7:0] a, logic w, logic [31:0] d, logic t);
    logic [2:0] ei;
    addr_i = a; we_i = w; wdata_i = d; tick_i = t;
    @(posedge clk_i);
    mupd(a, w, d, t);
    @(negedge clk_i);
    chk(tag == "" ? off_tag(a[4:0]) : tag, rdata_o, mread(a));
    for (int c = 0; c < 3; c++) ei[c] = m_pend[c] && m_ie[c];
    chk("R7", {29'd0, irq_o}, {29'd0, ei});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    for (int c = 0; c < 3; c++) begin
      m_load[c] = '0; m_cnt[c] = '0; m_rb[c] = '0; m_per[c] = 0; m_en[c] = 0;
      m_free[c] = 0; m_ie[c] = 0; m_pend[c] = 0; m_busy[c] = 0;
    end
    seed_dummy = $urandom(32'h5eed_0123);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    tag = "R1";
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 6; o++) step(8'(c * 32 + o * 4), 1'b0, '0, 1'b0);

    tag = "R2";
    step(8'h00, 1'b1, 32'd3, 1'b0);
    step(8'h0C, 1'b1, 32'h1, 1'b0);
    step(8'h08, 1'b1, 32'h80, 1'b0);
    step(8'h04, 1'b0, '0, 1'b0);
    tag = "R3";
    step(8'h04, 1'b0, '0, 1'b1);
    step(8'h04, 1'b0, '0, 1'b0);
    step(8'h04, 1'b0, '0, 1'b1);
    step(8'h04, 1'b0, '0, 1'b1);
    tag = "R4";
    step(8'h0C, 1'b0, '0, 1'b1);
    tag = "R5";
    step(8'h08, 1'b0, '0, 1'b1);
    step(8'h04, 1'b0, '0, 1'b1);
    chk("R5", rdata_o, 32'd0);

    tag = "R6";
    step(8'h20, 1'b1, 32'd2, 1'b0);
    step(8'h28, 1'b1, 32'hC0, 1'b0);
    for (int i = 0; i < 10; i++) step(8'h24, 1'b0, '0, 1'b1);

    tag = "R8";
    step(8'h0C, 1'b1, 32'h9, 1'b0);
    tag = "R10";
    step(8'h00, 1'b1, 32'h55, 1'b0);
    step(8'h08, 1'b1, 32'h80, 1'b0);
    step(8'h00, 1'b0, '0, 1'b0);
    chk("R10", rdata_o, 32'd3);
    step(8'h00, 1'b1, 32'h66, 1'b0);
    step(8'h00, 1'b0, '0, 1'b0);

    tag = "R11";
    step(8'h40, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(8'h4C, 1'b1, 32'h0, 1'b0);
    step(8'h48, 1'b1, 32'h1C0, 1'b0);
    for (int i = 0; i < 20; i++) step(8'h50, 1'b0, '0, 1'b1);
    chk("R6", ~rdata_o, 32'd19);

    tag = "R12";
    step(8'h08, 1'b1, 32'h0, 1'b1);
    step(8'h0C, 1'b1, 32'h8, 1'b1);
    step(8'h24, 1'b0, '0, 1'b1);
    step(8'h44, 1'b0, '0, 1'b1);

    tag = "";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int sel_off;
      sel_off = int'($urandom_range(0, 6));
      a[7:5] = 3'($urandom_range(0, 3));
      case (sel_off)
        0: a[4:0] = 5'h00;
        1: a[4:0] = 5'h04;
        2: a[4:0] = 5'h08;
        3, 6: a[4:0] = 5'h0C;
        4: a[4:0] = 5'h10;
        default: a[4:0] = 5'($urandom);
      endcase
      d = $urandom;
      if (a[4:0] == 5'h00) d = 32'($urandom_range(0, 7));
      step(a, ($urandom_range(0, 9) < 3), d, $urandom_range(0, 1) == 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule